// File: doc/BRIEF.md
# Multi-Channel Serial Receive Capture

This block gathers data from several serial input lines that share one serial clock and one frame select. Every input line is sampled on the same rising serial-clock edge. All lines share a single bit position counter, which moves forward on each falling serial-clock edge. A fixed number of bits at the start of each frame are thrown away. The bits that follow are packed into one parallel word per line, up to a fixed word length. When the last data bit has been stored, a one-cycle valid pulse is raised.

The whole block runs on the system clock. The serial clock, the active-low frame select and the data lines are brought into the system clock domain by synchronizers of equal depth, so all of them arrive with the same delay. Edges of the serial clock are then found by comparing the synchronized value with its value one cycle earlier. The serial clock is never used to clock a register. The block only receives: it does not make the serial clock and does not drive any output line toward the remote device.

Top module: `spi_multi_capture`

## Requirements
- R1: After reset, `data_out` is all zeros and `data_valid` is 0.
- R2: On one rising serial-clock edge, every one of the `NUM_CH` input lines is sampled. Line `c` is stored only into its own word, `data_out[c*WORD_BITS +: WORD_BITS]`.
- R3: Serial bit `n` is the bit sampled on the n-th rising edge after frame start, counting from 0. If `SKIP_BITS <= n < SKIP_BITS+WORD_BITS`, the bit is stored at word bit `n-SKIP_BITS`, so word bit 0 holds the first data bit. Bits with `n < SKIP_BITS` are discarded.
- R4: A falling edge of the synchronized `cs_n` (1 to 0) starts a frame. It sets the bit position back to 0 and clears `data_valid`, whatever was received before.
- R5: `data_valid` is high for exactly one system-clock cycle in each frame that reaches bit `SKIP_BITS+WORD_BITS-1`. It rises within 3 system clocks after the serial-clock rising edge that carries that bit.
- R6: Bits after bit `SKIP_BITS+WORD_BITS-1` change no word and raise no valid pulse, until the next frame start.
- R7: A word position that a frame does not reach keeps its earlier value. Frame start does not clear the words.
- R8: Serial-clock edges that arrive while `cs_n` is high (inactive) change no word and raise no valid pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| cs_n | input | 1 | Frame select, active low, asynchronous |
| sclk | input | 1 | Serial clock, asynchronous, sampled |
| miso | input | NUM_CH | Serial data lines, one per channel |
| data_out | output | NUM_CH*WORD_BITS | Captured words, channel c at bits c*WORD_BITS upward |
| data_valid | output | 1 | One-cycle pulse when the last data bit is stored |

## Verification
The assertions assume that each serial-clock level and each frame-select level lasts at least two system clocks, so that every edge is seen as one pulse. They also assume that the data lines are stable around every rising serial-clock edge. The bench holds each serial-clock half period for four system clocks and changes the data lines only half a period before each rising edge. It moves `cs_n` only while the serial clock is low and has been quiet for several cycles, so a frame start never falls in the same cycle as a serial edge.

// File: rtl/spi_cap_pkg.sv
package spi_cap_pkg;
  typedef struct packed {
    logic rise;
    logic fall;
  } edge_t;

  function automatic int idx_width(input int last_pos);
    return (last_pos < 2) ? 1 : $clog2(last_pos + 1);
  endfunction
endpackage

// File: rtl/spi_cap_sync.sv
module spi_cap_sync #(
  parameter int W      = 3,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] async_in,
  output logic [W-1:0] sync_out,
  output logic [W-1:0] prev_out
);
  logic [W-1:0] stage_q [STAGES];

  always_ff @(posedge clk) begin
    if (rst) stage_q[0] <= '0;
    else     stage_q[0] <= async_in;
  end

  for (genvar s = 1; s < STAGES; s++) begin : g_stage
    always_ff @(posedge clk) begin
      if (rst) stage_q[s] <= '0;
      else     stage_q[s] <= stage_q[s-1];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) prev_out <= '0;
    else     prev_out <= stage_q[STAGES-1];
  end

  assign sync_out = stage_q[STAGES-1];
endmodule

// File: rtl/spi_cap_index.sv
module spi_cap_index #(
  parameter int SKIP_BITS = 2,
  parameter int WORD_BITS = 8,
  localparam int END_POS  = SKIP_BITS + WORD_BITS,
  localparam int IW       = spi_cap_pkg::idx_width(END_POS)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          start,
  input  logic          advance,
  output logic [IW-1:0] idx,
  output logic          in_window,
  output logic          last_bit
);
  logic at_or_past_skip;

  always_ff @(posedge clk) begin
    if (rst || start)                       idx <= '0;
    else if (advance && idx != IW'(END_POS)) idx <= idx + 1'b1;
  end

  if (SKIP_BITS == 0) begin : g_noskip
    assign at_or_past_skip = 1'b1;
  end else begin : g_skip
    assign at_or_past_skip = (idx >= IW'(SKIP_BITS));
  end

  assign in_window = at_or_past_skip && (idx < IW'(END_POS));
  assign last_bit  = (idx == IW'(END_POS - 1));

  // R6
  idx_saturate_chk: assert property (@(posedge clk) disable iff (rst)
    idx <= IW'(END_POS));
  // R4
  idx_restart_chk: assert property (@(posedge clk) disable iff (rst)
    start |=> (idx == '0));
  // R3
  idx_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (!start && !advance) |=> $stable(idx));
endmodule

// File: rtl/spi_cap_lane.sv
module spi_cap_lane #(
  parameter int WORD_BITS = 8,
  parameter int IW        = 4
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 wr_en,
  input  logic [IW-1:0]        pos,
  input  logic                 bit_in,
  output logic [WORD_BITS-1:0] word_q
);
  always_ff @(posedge clk) begin
    if (rst) begin
      word_q <= '0;
    end else if (wr_en) begin
      for (int k = 0; k < WORD_BITS; k++) begin
        if (pos == IW'(k)) word_q[k] <= bit_in;
      end
    end
  end

  // R7
  word_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !wr_en |=> $stable(word_q));
  // R2
  single_bit_chk: assert property (@(posedge clk) disable iff (rst)
    wr_en |=> ($countones(word_q ^ $past(word_q)) <= 1));
endmodule

// File: rtl/spi_multi_capture.sv
module spi_multi_capture #(
  parameter int NUM_CH      = 4,
  parameter int SKIP_BITS   = 2,
  parameter int WORD_BITS   = 8,
  parameter int SYNC_STAGES = 2,
  localparam int END_POS    = SKIP_BITS + WORD_BITS,
  localparam int IW         = spi_cap_pkg::idx_width(END_POS),
  localparam int SW         = NUM_CH + 2
) (
  input  logic                        clk,
  input  logic                        rst,
  input  logic                        cs_n,
  input  logic                        sclk,
  input  logic [NUM_CH-1:0]           miso,
  output logic [NUM_CH*WORD_BITS-1:0] data_out,
  output logic                        data_valid
);
  import spi_cap_pkg::*;

  logic [SW-1:0] sync_v, prev_v;
  logic [NUM_CH-1:0] miso_s;
  logic cs_s, cs_p;
  edge_t sck_edge;
  logic frame_start, active, cap_en, adv_en;
  logic [IW-1:0] idx, pos;
  logic in_window, last_bit;

  spi_cap_sync #(.W(SW), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst(rst),
    .async_in({cs_n, sclk, miso}),
    .sync_out(sync_v), .prev_out(prev_v)
  );

  assign miso_s        = sync_v[NUM_CH-1:0];
  assign cs_s          = sync_v[NUM_CH+1];
  assign cs_p          = prev_v[NUM_CH+1];
  assign sck_edge.rise = sync_v[NUM_CH] & ~prev_v[NUM_CH];
  assign sck_edge.fall = ~sync_v[NUM_CH] & prev_v[NUM_CH];

  assign frame_start = cs_p & ~cs_s;
  assign active      = ~cs_s & ~frame_start;
  assign cap_en      = sck_edge.rise & active & in_window;
  assign adv_en      = sck_edge.fall & active;

  spi_cap_index #(.SKIP_BITS(SKIP_BITS), .WORD_BITS(WORD_BITS)) u_index (
    .clk(clk), .rst(rst), .start(frame_start), .advance(adv_en),
    .idx(idx), .in_window(in_window), .last_bit(last_bit)
  );

  assign pos = idx - IW'(SKIP_BITS);

  for (genvar c = 0; c < NUM_CH; c++) begin : g_lane
    spi_cap_lane #(.WORD_BITS(WORD_BITS), .IW(IW)) u_lane (
      .clk(clk), .rst(rst), .wr_en(cap_en), .pos(pos),
      .bit_in(miso_s[c]),
      .word_q(data_out[c*WORD_BITS +: WORD_BITS])
    );
  end

  always_ff @(posedge clk) begin
    if (rst || frame_start) data_valid <= 1'b0;
    else                    data_valid <= cap_en & last_bit;
  end

  // R5
  valid_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    data_valid |=> !data_valid);
  // R4
  start_clears_valid_chk: assert property (@(posedge clk) disable iff (rst)
    frame_start |=> !data_valid);
  // R8
  idle_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    cs_s |=> ($stable(data_out) && !data_valid));
endmodule

// File: tb/spi_multi_capture_tb.sv
module spi_multi_capture_tb;
  localparam int NUM_CH = 4;
  localparam int SKIP   = 2;
  localparam int WB     = 8;
  localparam int ENDP   = SKIP + WB;
  localparam int HALF   = 4;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic cs_n = 1'b1;
  logic sclk = 1'b0;
  logic [NUM_CH-1:0] miso = '0;
  logic [NUM_CH*WB-1:0] data_out;
  logic data_valid;

  int n_vec = 0;
  int n_bad = 0;
  int pulses = 0;
  logic prev_valid = 1'b0;
  logic [WB-1:0] exp_w [NUM_CH];

  always #10 clk = ~clk;

  spi_multi_capture #(.NUM_CH(NUM_CH), .SKIP_BITS(SKIP), .WORD_BITS(WB)) u_dut (
    .clk(clk), .rst(rst), .cs_n(cs_n), .sclk(sclk), .miso(miso),
    .data_out(data_out), .data_valid(data_valid)
  );

  always @(negedge clk) begin
    if (!rst) begin
      if (data_valid) pulses++;
      if (data_valid && prev_valid) begin
        n_bad++;
        $display("FAIL R5: valid high two cycles, got 2 expected 1");
      end
    end
    prev_valid <= data_valid;
  end

  task automatic wclk(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic check(input string tag, input logic [63:0] got, input logic [63:0] want);
    n_vec++;
    if (got !== want) begin
      n_bad++;
      $display("FAIL %s: got %h expected %h", tag, got, want);
    end
  endtask

  function automatic logic [NUM_CH*WB-1:0] packed_exp();
    logic [NUM_CH*WB-1:0] v;
    for (int c = 0; c < NUM_CH; c++) v[c*WB +: WB] = exp_w[c];
    return v;
  endfunction

  // One frame of nbits serial bits; bits[n] holds the value of every line for bit n.
  task automatic frame(input int nbits, input logic [NUM_CH-1:0] bits [64], input string tag);
    int p0;
    cs_n = 1'b0;
    wclk(6);
    p0 = pulses;
    for (int n = 0; n < nbits; n++) begin
      miso = bits[n];
      wclk(HALF);
      sclk = 1'b1;
      wclk(HALF);
      if (n == ENDP - 1)
        check({tag, " R5 pulse after last bit"}, 64'(pulses - p0), 64'd1);
      else if (n == ENDP - 2)
        check({tag, " R5 no early pulse"}, 64'(pulses - p0), 64'd0);
      sclk = 1'b0;
      if (n >= SKIP && n < ENDP)
        for (int c = 0; c < NUM_CH; c++) exp_w[c][n - SKIP] = bits[n][c];
    end
    wclk(6);
    cs_n = 1'b1;
    wclk(6);
    check({tag, " R3 R6 R7 words"}, 64'(data_out), 64'(packed_exp()));
    check({tag, " R5 pulse count"}, 64'(pulses - p0), (nbits >= ENDP) ? 64'd1 : 64'd0);
  endtask

  task automatic rand_frame(input int nbits, input string tag);
    logic [NUM_CH-1:0] bits [64];
    for (int n = 0; n < 64; n++) bits[n] = NUM_CH'($urandom);
    frame(nbits, bits, tag);
  endtask

  initial begin
    logic [NUM_CH-1:0] pat [64];
    int p0;
    void'($urandom(32'd2024));
    for (int c = 0; c < NUM_CH; c++) exp_w[c] = '0;
    wclk(4);
    rst = 1'b0;
    wclk(2);
    // R1 reset state
    check("R1 data_out", 64'(data_out), 64'd0);
    check("R1 data_valid", 64'(data_valid), 64'd0);

    // R2: each line carries a distinct pattern; R3: leading bits are set high
    for (int n = 0; n < 64; n++)
      for (int c = 0; c < NUM_CH; c++)
        pat[n][c] = (n < SKIP) ? 1'b1 : (((n - SKIP) >> c) & 1) == 0;
    frame(ENDP, pat, "R2 distinct lines");

    rand_frame(ENDP, "R3 exact length");
    rand_frame(SKIP + 3, "R7 short frame");
    rand_frame(ENDP + 3, "R6 long frame");
    rand_frame(SKIP, "R3 skip only");
    rand_frame(0, "R4 empty frame");

    // R8: serial edges while frame select inactive
    p0 = pulses;
    for (int n = 0; n < ENDP + 2; n++) begin
      miso = NUM_CH'($urandom);
      wclk(HALF); sclk = 1'b1; wclk(HALF); sclk = 1'b0;
    end
    wclk(6);
    check("R8 words unchanged", 64'(data_out), 64'(packed_exp()));
    check("R8 no pulse", 64'(pulses - p0), 64'd0);

    for (int f = 0; f < 20; f++)
      rand_frame(int'($urandom_range(ENDP + 4, 1)), "R4 random frame");

    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    #2000000;
    n_bad++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule